// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A character enters through a valid/ready handshake. The block then drives a start bit, the data bits least significant first, an optional parity bit and one or more stop bits. Bit timing comes from a clock-enable tick input. A selectable multiplier sets how many ticks make up one bit period, so the block does not generate its own baud rate.

Configuration inputs set the character length, the number of stop bits, the parity enable and parity sense, and the tick multiplier. The block samples these inputs when it accepts a character, so the frame in progress does not change if they change. A break request forces the line to the spacing level for as long as the request stays high. A request that arrives during a frame waits until that frame has finished. When the request is released, the line returns to mark for one bit period before another character can be accepted.

Top module: `async_char_tx`

## Requirements
- R1: After reset the line is at mark (txOut=1), inReady=1, idle=1 and busy=0.
- R2: A character is accepted on a clock edge where inValid and inReady are both 1. inReady is 1 only while idle with breakReq low. busy is 1 from the cycle after acceptance through the end of the last stop bit, and then idle returns to 1.
- R3: A frame starts with one bit period at 0, followed by the data bits LSB first. dataLen codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and data bits above the selected length have no effect on the line.
- R4: When parityEn=1, one parity bit follows the data. With parityOdd=0 it is the XOR of the sent data bits (even parity), and with parityOdd=1 it is the inverse of that XOR (odd parity).
- R5: multSel codes 0, 1, 2 and 3 make one bit period 1, 16, 32 or 64 ticks. A cycle with tick=0 does not advance the frame.
- R6: stopSel code 0 gives 1 stop bit period at 1, code 1 gives 1.5 periods, and codes 2 and 3 give 2 periods.
- R7: With multSel=0, stopSel code 1 gives 2 stop ticks.
- R8: Changes to multSel, dataLen, stopSel, parityEn and parityOdd after a character has been accepted do not affect that frame.
- R9: breakReq=1 while idle drives the line to 0 from the next cycle on, holds it there while the request stays high, and accepts no character during that time.
- R10: breakReq raised during a frame does not cut the frame short. The break starts only after the last stop bit.
- R11: After breakReq falls, the line stays at 1 for one bit period, using the multSel in effect at release, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for bit timing |
| multSel | input | 2 | Ticks per bit: 0→1, 1→16, 2→32, 3→64 |
| dataLen | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| stopSel | input | 2 | Stop length: 0→1, 1→1.5, 2/3→2 bit periods |
| parityEn | input | 1 | Insert a parity bit |
| parityOdd | input | 1 | 1 for odd parity, 0 for even parity |
| breakReq | input | 1 | Hold the line at spacing |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Character can be accepted |
| inData | input | 8 | Character, LSB sent first |
| txOut | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| idle | output | 1 | No frame, no break and no post-break mark |

## Verification
The hardest condition to reach from the ports is a break request that arrives while a frame is on the line. The stimulus raises breakReq on the cycle right after a character is accepted, checks the whole frame bit by bit, and then confirms that the line drops to spacing only after the last stop bit and that the post-break mark lasts exactly one bit period. Frames are also run with sparse ticks and with the configuration inputs changed in the middle of the frame, so that timing and sampled settings are checked apart from the clock rate.

// File: rtl/async_tx_pkg.sv
`timescale 1ns/1ps
package async_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int MIN_LEN = 5;
  localparam int TICK_W  = 8;
  localparam int IDX_W   = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_BREAK, ST_RECOVER
  } txState_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic parity;
    logic mark;
    logic space;
  } txStrobe_t;

  function automatic logic [TICK_W-1:0] bitTicks(input logic [1:0] m);
    case (m)
      2'd0:    return TICK_W'(1);
      2'd1:    return TICK_W'(16);
      2'd2:    return TICK_W'(32);
      default: return TICK_W'(64);
    endcase
  endfunction

  function automatic logic [TICK_W-1:0] stopTicks(input logic [1:0] m, input logic [1:0] s);
    logic [TICK_W-1:0] b;
    b = bitTicks(m);
    case (s)
      2'd0:    return b;
      2'd1:    return (m == 2'd0) ? TICK_W'(2) : b + (b >> 1);
      default: return b << 1;
    endcase
  endfunction
endpackage

// File: rtl/async_tx_dp.sv
`timescale 1ns/1ps
module async_tx_dp
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              parityOdd,
  output logic              txOut
);
  logic [DATA_W-1:0] shiftReg;
  logic              parAcc;
  logic              oddQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      oddQ     <= 1'b0;
      txOut    <= 1'b1;
    end else if (strobe.load) begin
      shiftReg <= inData;
      parAcc   <= 1'b0;
      oddQ     <= parityOdd;
      txOut    <= 1'b0;
    end else if (strobe.shift) begin
      txOut    <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
      parAcc   <= parAcc ^ shiftReg[0];
    end else if (strobe.parity) begin
      txOut <= parAcc ^ oddQ;
    end else if (strobe.mark) begin
      txOut <= 1'b1;
    end else if (strobe.space) begin
      txOut <= 1'b0;
    end
  end
endmodule

// File: rtl/async_tx_ctrl.sv
`timescale 1ns/1ps
module async_tx_ctrl
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] multSel,
  input  logic [1:0] dataLen,
  input  logic [1:0] stopSel,
  input  logic       parityEn,
  input  logic       breakReq,
  input  logic       inValid,
  output logic       inReady,
  output logic       busy,
  output logic       idle,
  output txStrobe_t  strobe
);
  txState_e          state, stNext;
  logic [TICK_W-1:0] tickCnt, segLen;
  logic [IDX_W-1:0]  bitIdx, nBits;
  logic [1:0]        multQ, lenQ, stopQ;
  logic              parQ;
  logic              segEnd, clrCnt, idxLoad, idxInc;

  assign nBits  = IDX_W'(MIN_LEN) + IDX_W'(lenQ);
  assign segLen = (state == ST_STOP) ? stopTicks(multQ, stopQ) : bitTicks(multQ);
  assign segEnd = tick && (tickCnt == segLen - TICK_W'(1));

  always_comb begin
    stNext  = state;
    strobe  = '0;
    clrCnt  = 1'b0;
    idxLoad = 1'b0;
    idxInc  = 1'b0;
    case (state)
      ST_IDLE: begin
        clrCnt = 1'b1;
        if (breakReq) begin
          stNext       = ST_BREAK;
          strobe.space = 1'b1;
        end else if (inValid) begin
          stNext      = ST_START;
          strobe.load = 1'b1;
        end
      end
      ST_START: if (segEnd) begin
        stNext       = ST_DATA;
        strobe.shift = 1'b1;
        clrCnt       = 1'b1;
        idxLoad      = 1'b1;
      end
      ST_DATA: if (segEnd) begin
        clrCnt = 1'b1;
        if (bitIdx < nBits) begin
          strobe.shift = 1'b1;
          idxInc       = 1'b1;
        end else if (parQ) begin
          stNext        = ST_PARITY;
          strobe.parity = 1'b1;
        end else begin
          stNext      = ST_STOP;
          strobe.mark = 1'b1;
        end
      end
      ST_PARITY: if (segEnd) begin
        stNext      = ST_STOP;
        strobe.mark = 1'b1;
        clrCnt      = 1'b1;
      end
      ST_STOP: if (segEnd) begin
        stNext = ST_IDLE;
        clrCnt = 1'b1;
      end
      ST_BREAK: begin
        clrCnt = 1'b1;
        if (!breakReq) begin
          stNext      = ST_RECOVER;
          strobe.mark = 1'b1;
        end
      end
      ST_RECOVER: if (segEnd) begin
        stNext = ST_IDLE;
        clrCnt = 1'b1;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      multQ   <= '0;
      lenQ    <= '0;
      stopQ   <= '0;
      parQ    <= 1'b0;
    end else begin
      state <= stNext;
      if (clrCnt)    tickCnt <= '0;
      else if (tick) tickCnt <= tickCnt + TICK_W'(1);
      if (idxLoad)     bitIdx <= IDX_W'(1);
      else if (idxInc) bitIdx <= bitIdx + IDX_W'(1);
      if (state == ST_IDLE || state == ST_BREAK) begin
        multQ <= multSel;
        lenQ  <= dataLen;
        stopQ <= stopSel;
        parQ  <= parityEn;
      end
    end
  end

  assign inReady = (state == ST_IDLE) && !breakReq;
  assign idle    = (state == ST_IDLE);
  assign busy    = (state == ST_START) || (state == ST_DATA) ||
                   (state == ST_PARITY) || (state == ST_STOP);
endmodule

// File: rtl/async_char_tx.sv
`timescale 1ns/1ps
module async_char_tx
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [1:0]        multSel,
  input  logic [1:0]        dataLen,
  input  logic [1:0]        stopSel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              breakReq,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              txOut,
  output logic              busy,
  output logic              idle
);
  txStrobe_t strobe;

  async_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .multSel(multSel), .dataLen(dataLen),
    .stopSel(stopSel), .parityEn(parityEn), .breakReq(breakReq), .inValid(inValid),
    .inReady(inReady), .busy(busy), .idle(idle), .strobe(strobe)
  );

  async_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .parityOdd(parityOdd), .txOut(txOut)
  );
endmodule

// File: rtl/async_tx_chk.sv
`timescale 1ns/1ps
module async_tx_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic breakReq,
  input logic inValid,
  input logic inReady,
  input logic txOut,
  input logic busy,
  input logic idle
);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> txOut);

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (idle && !busy));

  assert_frame_end_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> idle);

  assert_accept_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (!txOut && busy));

  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> $stable(txOut));

  assert_break_space_R9: assert property (@(posedge clk) disable iff (!rstN)
    (idle && breakReq) |=> (!txOut && !inReady));
endmodule

bind async_char_tx async_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .breakReq(breakReq), .inValid(inValid),
  .inReady(inReady), .txOut(txOut), .busy(busy), .idle(idle)
);

// File: tb/async_char_tx_test.sv
`timescale 1ns/1ps
module async_char_tx_test;
  logic       clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic [1:0] multSel = '0, dataLen = '0, stopSel = '0;
  logic       parityEn = 1'b0, parityOdd = 1'b0, breakReq = 1'b0, inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inReady, txOut, busy, idle;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int segLvl[16];
  int segDur[16];
  int nSeg;

  always #5 clk = ~clk;

  async_char_tx uut (
    .clk(clk), .rstN(rstN), .tick(tick), .multSel(multSel), .dataLen(dataLen),
    .stopSel(stopSel), .parityEn(parityEn), .parityOdd(parityOdd), .breakReq(breakReq),
    .inValid(inValid), .inReady(inReady), .inData(inData), .txOut(txOut),
    .busy(busy), .idle(idle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bitLen(input int m);
    return (m == 0) ? 1 : (8 << m);
  endfunction

  task automatic buildFrame(input logic [7:0] d, input int len, input int stop,
                            input int par, input int m);
    int b, n, p;
    b = bitLen(m);
    n = 5 + len;
    nSeg = 0;
    segLvl[nSeg] = 0; segDur[nSeg] = b; nSeg++;
    p = 0;
    for (int i = 0; i < n; i++) begin
      segLvl[nSeg] = int'(d[i]); segDur[nSeg] = b; nSeg++;
      p = p ^ int'(d[i]);
    end
    if (par != 0) begin
      segLvl[nSeg] = (par == 2) ? 1 - p : p; segDur[nSeg] = b; nSeg++;
    end
    segLvl[nSeg] = 1;
    segDur[nSeg] = (stop == 0) ? b : (stop == 1) ? ((m == 0) ? 2 : b + b / 2) : 2 * b;
    nSeg++;
  endtask

  // Starts at a negedge; checks each cycle and drives tick every gap cycles.
  task automatic playSegs(input string req, input int gap, input bit expBusy);
    int phase = 0;
    bit bad = 1'b0;
    int act = 0, exp = 0;
    for (int s = 0; s < nSeg; s++) begin
      int rem = segDur[s];
      while (rem > 0) begin
        if (!bad && !(txOut === segLvl[s][0] && busy === expBusy && inReady === 1'b0)) begin
          bad = 1'b1;
          act = int'(txOut);
          exp = segLvl[s];
          $display("  segment %0d mismatch: busy=%b ready=%b", s, busy, inReady);
        end
        tick = ((phase % gap) == 0);
        phase++;
        if (tick) rem--;
        @(negedge clk);
      end
    end
    tick = 1'b0;
    check(!bad, req, act, exp);
  endtask

  task automatic runFrame(input logic [7:0] d, input int len, input int stop, input int par,
                          input int m, input int gap, input bit scramble, input bit brk,
                          input string req);
    @(negedge clk);
    multSel = 2'(m); dataLen = 2'(len); stopSel = 2'(stop);
    parityEn = (par != 0); parityOdd = (par == 2);
    inData = d; inValid = 1'b1; tick = 1'b0;
    buildFrame(d, len, stop, par, m);
    @(negedge clk);
    inValid = 1'b0;
    breakReq = brk;
    if (scramble) begin
      multSel = ~multSel; dataLen = ~dataLen; stopSel = stopSel ^ 2'd1;
      parityEn = ~parityEn; parityOdd = ~parityOdd; inData = ~inData;
    end
    playSegs(req, gap, 1'b1);
    check(idle === 1'b1 && txOut === 1'b1 && inReady === !brk,
          "R2 idle after stop", int'({idle, txOut, inReady}), int'({2'b11, !brk}));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txOut === 1'b1, "R1 reset txOut", int'(txOut), 1);
    check(inReady === 1'b1, "R1 reset inReady", int'(inReady), 1);
    check(idle === 1'b1, "R1 reset idle", int'(idle), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);

    // Sweep: R3 R4 R5 R6 R7 R8, config scrambled after acceptance
    for (int m = 0; m < 4; m++)
      for (int len = 0; len < 4; len++)
        for (int stop = 0; stop < 3; stop++)
          for (int par = 0; par < 3; par++) begin
            logic [7:0] d;
            d = 8'hA5 ^ 8'((m * 61 + len * 37 + stop * 19 + par * 7) & 255);
            runFrame(d, len, stop, par, m, 1, 1'b1, 1'b0,
                     (m == 0 && stop == 1) ? "R7 x1 one-and-half stop" : "R3 R4 R5 R6 R8 frame");
          end

    runFrame(8'h96, 3, 3, 0, 1, 1, 1'b0, 1'b0, "R6 stop code 3");
    runFrame(8'hE0, 0, 0, 1, 0, 1, 1'b0, 1'b0, "R3 upper bits ignored");
    runFrame(8'h3C, 2, 1, 1, 1, 3, 1'b0, 1'b0, "R5 sparse ticks x16");
    runFrame(8'hF1, 3, 0, 2, 0, 2, 1'b0, 1'b0, "R5 sparse ticks x1");

    // R9: break while idle, inValid held high
    @(negedge clk);
    multSel = 2'd1; breakReq = 1'b1; inValid = 1'b1; inData = 8'h55; tick = 1'b1;
    @(negedge clk);
    check(txOut === 1'b0 && inReady === 1'b0 && idle === 1'b0 && busy === 1'b0,
          "R9 break entry", int'({txOut, inReady, idle, busy}), 0);
    begin
      bit held = 1'b1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (txOut !== 1'b0 || inReady !== 1'b0) held = 1'b0;
      end
      check(held, "R9 break held", int'(held), 1);
    end
    inValid = 1'b0; breakReq = 1'b0; tick = 1'b0;
    @(negedge clk);
    nSeg = 1; segLvl[0] = 1; segDur[0] = 16;
    playSegs("R11 mark after break x16", 1, 1'b0);
    check(idle === 1'b1 && inReady === 1'b1 && txOut === 1'b1, "R11 idle after recovery",
          int'({idle, inReady, txOut}), 7);

    // R10: break requested mid-frame
    runFrame(8'hC3, 3, 0, 0, 0, 1, 1'b0, 1'b1, "R10 frame completes under break");
    @(negedge clk);
    check(txOut === 1'b0 && idle === 1'b0, "R10 break after frame", int'({txOut, idle}), 0);
    breakReq = 1'b0;
    @(negedge clk);
    nSeg = 1; segLvl[0] = 1; segDur[0] = 1;
    playSegs("R11 mark after break x1", 1, 1'b0);
    check(idle === 1'b1 && inReady === 1'b1, "R11 ready after x1 recovery",
          int'({idle, inReady}), 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule